// File: doc/BRIEF.md
# Boot Program Copy Engine

This block keeps a short boot program in a small word-addressed store that stays powered while the rest of the subsystem sleeps. On request it copies a run of 32-bit words from that store into the instruction memory of an embedded processor, then lets the processor run. The host fills the store and programs the copy through a simple memory-mapped register bus. It sets the source word offset, the destination word address and the word count.

A copy starts in one of two ways. The host can set the start bit, or a power-up event can trigger it while the auto-reload enable is set. The enabled case reloads the instruction image after every sleep. The processor-run output is held low from the start of a copy until the last word has gone out. Four general-purpose pointer registers sit in the same window for the boot program's own use.

Top module: `boot_copy_engine`

## Requirements
- R1: After reset, cpu_run_o is 0 and imem_we_o is 0. The control register (byte offset 0x000) and the status register (0x010) read 0.
- R2: A bus write to 0x000 with bit 31 set starts a copy from the next cycle. While the copy runs, bit 31 of 0x000 reads 1. It reads 0 once the copy ends.
- R3: A copy of N words writes one word per cycle for N cycles. Word i goes to address dst+i and comes from store word src+i. The source offset is at 0x004, the destination at 0x008 and the count at 0x00C.
- R4: Source indices wrap modulo the 256-word store.
- R5: Bit 0 of the status register at 0x010 is cleared when a copy of one or more words starts. It is set when that copy completes.
- R6: cpu_run_o is 0 from the cycle after a start until the last word is written. It becomes 1 in the cycle after the last write.
- R7: A start with a count of 0 writes no word. In the next cycle the status bit and cpu_run_o are 1 and bit 31 of 0x000 reads 0.
- R8: Bit 30 of 0x000 is a readable auto-reload enable. While it is set, a pulse on pwr_up_i starts a copy with the programmed parameters.
- R9: A pwr_up_i pulse does nothing when bit 30 is clear. A pwr_up_i pulse during a running copy is also ignored.
- R10: Bus writes to 0x004, 0x008 and 0x00C during a running copy are ignored. Both the running copy and later reads show the old values.
- R11: The store is read/write from the bus as 32-bit words at byte offsets 0x400 to 0x7FC. Copies leave its contents unchanged.
- R12: The four pointer registers at 0x090, 0x094, 0x098 and 0x09C read back all 32 written bits, including bit 31 of 0x094.
- R13: Read data appears on reg_rdata_o in the cycle after the read request. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register bus request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address within the block window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| pwr_up_i | input | 1 | Power-up event pulse |
| imem_we_o | output | 1 | Instruction memory write strobe |
| imem_addr_o | output | 16 | Instruction memory word address |
| imem_wdata_o | output | 32 | Instruction memory write data |
| cpu_run_o | output | 1 | Processor release |

## Verification
A start sampled at a clock edge shows up after that edge: the first instruction-memory write is present, and cpu_run_o has dropped. The last write is visible for one cycle, and cpu_run_o rises at the next edge. Read data is due one cycle after the request edge.

The bench drives every input on the falling edge and keeps a behavioural model that advances on the rising edge. It compares the strobe, address, data, run output and any due read word against that model at each falling edge. Directed checks sample at those same points.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  localparam int unsigned OFS_CTRL   = 'h000;
  localparam int unsigned OFS_SRC    = 'h004;
  localparam int unsigned OFS_DST    = 'h008;
  localparam int unsigned OFS_CNT    = 'h00C;
  localparam int unsigned OFS_STAT   = 'h010;
  localparam int unsigned OFS_PTR0   = 'h090;
  localparam int unsigned OFS_STORE  = 'h400;
  localparam int unsigned CTRL_GO    = 31;
  localparam int unsigned CTRL_AUTO  = 30;
endpackage

// File: rtl/boot_store.sv
module boot_store #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_idx_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [AW-1:0] cp_idx_i,
  output logic [DW-1:0] cp_rdata_o
);
  // no reset: contents survive sleep
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (bus_we_i) mem_q[bus_idx_i] <= bus_wdata_i;
  end

  assign bus_rdata_o = mem_q[bus_idx_i];
  assign cp_rdata_o  = mem_q[cp_idx_i];
endmodule

// File: rtl/copy_seq.sv
module copy_seq #(
  parameter int unsigned SAW   = 8,
  parameter int unsigned IAW   = 16,
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SAW-1:0]   src_i,
  input  logic [IAW-1:0]   dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             run_o,
  output logic [SAW-1:0]   rd_idx_o,
  output logic             imem_we_o,
  output logic [IAW-1:0]   imem_addr_o
);
  logic             busy_q, done_q, run_q;
  logic [CNT_W-1:0] idx_q, cnt_q;
  logic [SAW-1:0]   src_q;
  logic [IAW-1:0]   dst_q;
  logic             last_w;

  assign last_w = (idx_q == cnt_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (last_w) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        run_q  <= 1'b1;
      end
    end else if (start_i) begin
      if (cnt_i == '0) begin
        done_q <= 1'b1;
        run_q  <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        run_q  <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= cnt_i;
        src_q  <= src_i;
        dst_q  <= dst_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign run_o       = run_q;
  assign imem_we_o   = busy_q;
  assign rd_idx_o    = src_q + idx_q[SAW-1:0];
  assign imem_addr_o = dst_q + IAW'(idx_q);
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 32,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] regs_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_q[g] <= '0;
      else if (we_i && sel_i == SW'(g))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[sel_i];
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import boot_copy_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DW          = 32,
  parameter int unsigned STORE_WORDS = 256,
  parameter int unsigned IMEM_AW     = 16,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned N_PTR       = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               pwr_up_i,
  output logic               imem_we_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  output logic [DW-1:0]      imem_wdata_o,
  output logic               cpu_run_o
);
  localparam int unsigned SAW      = $clog2(STORE_WORDS);
  localparam int unsigned PSW      = (N_PTR > 1) ? $clog2(N_PTR) : 1;
  localparam int unsigned STORE_HI = OFS_STORE + 4 * STORE_WORDS;
  localparam int unsigned PTR_HI   = OFS_PTR0 + 4 * N_PTR;

  logic             wr, rd;
  logic             hit_ctrl, hit_src, hit_dst, hit_cnt, hit_stat, hit_ptr, hit_store;
  logic [SAW-1:0]   src_q;
  logic [IMEM_AW-1:0] dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             auto_q;
  logic             busy, done, host_start, start;
  logic [SAW-1:0]   cp_idx;
  logic [DW-1:0]    store_bus_rd, ptr_rd, rd_mux;

  assign wr = reg_req_i & reg_we_i;
  assign rd = reg_req_i & ~reg_we_i;

  assign hit_ctrl  = reg_addr_i == ADDR_W'(OFS_CTRL);
  assign hit_src   = reg_addr_i == ADDR_W'(OFS_SRC);
  assign hit_dst   = reg_addr_i == ADDR_W'(OFS_DST);
  assign hit_cnt   = reg_addr_i == ADDR_W'(OFS_CNT);
  assign hit_stat  = reg_addr_i == ADDR_W'(OFS_STAT);
  assign hit_ptr   = (reg_addr_i >= ADDR_W'(OFS_PTR0)) && (reg_addr_i < ADDR_W'(PTR_HI))
                     && (reg_addr_i[1:0] == 2'b00);
  assign hit_store = (reg_addr_i >= ADDR_W'(OFS_STORE)) && ({1'b0, reg_addr_i} < (ADDR_W+1)'(STORE_HI))
                     && (reg_addr_i[1:0] == 2'b00);

  assign host_start = wr & hit_ctrl & reg_wdata_i[CTRL_GO];
  assign start      = (host_start | (pwr_up_i & auto_q)) & ~busy;

  // parameters frozen while a copy runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      auto_q <= 1'b0;
    end else if (wr) begin
      if (hit_ctrl)          auto_q <= reg_wdata_i[CTRL_AUTO];
      if (hit_src && !busy)  src_q  <= reg_wdata_i[SAW-1:0];
      if (hit_dst && !busy)  dst_q  <= reg_wdata_i[IMEM_AW-1:0];
      if (hit_cnt && !busy)  cnt_q  <= reg_wdata_i[CNT_W-1:0];
    end
  end

  boot_store #(.WORDS(STORE_WORDS), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .bus_we_i   (wr & hit_store),
    .bus_idx_i  (reg_addr_i[SAW+1:2]),
    .bus_wdata_i(reg_wdata_i),
    .bus_rdata_o(store_bus_rd),
    .cp_idx_i   (cp_idx),
    .cp_rdata_o (imem_wdata_o)
  );

  copy_seq #(.SAW(SAW), .IAW(IMEM_AW), .CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .src_i      (src_q),
    .dst_i      (dst_q),
    .cnt_i      (cnt_q),
    .busy_o     (busy),
    .done_o     (done),
    .run_o      (cpu_run_o),
    .rd_idx_o   (cp_idx),
    .imem_we_o  (imem_we_o),
    .imem_addr_o(imem_addr_o)
  );

  ptr_bank #(.N(N_PTR), .DW(DW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr & hit_ptr),
    .sel_i  (reg_addr_i[PSW+1:2]),
    .wdata_i(reg_wdata_i),
    .rdata_o(ptr_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CTRL_GO]   = busy;
      rd_mux[CTRL_AUTO] = auto_q;
    end
    if (hit_src)   rd_mux = DW'(src_q);
    if (hit_dst)   rd_mux = DW'(dst_q);
    if (hit_cnt)   rd_mux = DW'(cnt_q);
    if (hit_stat)  rd_mux = DW'(done);
    if (hit_ptr)   rd_mux = ptr_rd;
    if (hit_store) rd_mux = store_bus_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  reg_rdata_o <= '0;
    else if (rd)  reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/boot_copy_checks.sv
module boot_copy_checks #(
  parameter int unsigned IMEM_AW = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               imem_we_i,
  input logic [IMEM_AW-1:0] imem_addr_i,
  input logic               cpu_run_i,
  input logic               pwr_up_i,
  input logic               auto_en_i,
  input logic               host_start_i,
  input logic               done_i
);
  p_run_low_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_i |-> !cpu_run_i);

  p_run_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(imem_we_i) |-> cpu_run_i);

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_we_i && $past(imem_we_i)) |-> imem_addr_i == $past(imem_addr_i) + 1'b1);

  p_pwr_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_up_i && !auto_en_i && !imem_we_i && !host_start_i) |=> !imem_we_i);

  p_done_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_i |-> !done_i);

  p_done_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(imem_we_i) |-> done_i);
endmodule

bind boot_copy_engine boot_copy_checks #(.IMEM_AW(IMEM_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_we_i   (imem_we_o),
  .imem_addr_i (imem_addr_o),
  .cpu_run_i   (cpu_run_o),
  .pwr_up_i    (pwr_up_i),
  .auto_en_i   (auto_q),
  .host_start_i(host_start),
  .done_i      (done)
);

// File: tb/boot_copy_engine_test.sv
`timescale 1ns/1ps
module boot_copy_engine_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, pwr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, imem_wdata;
  logic [15:0] imem_addr;
  logic        imem_we, run;

  int n_tests = 0, n_fail = 0, n_writes = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_copy_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pwr_up_i(pwr), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
    .imem_wdata_o(imem_wdata), .cpu_run_o(run)
  );

  // behavioural reference
  logic [31:0] m_store [256];
  logic [31:0] m_ptr [4];
  int m_src = 0, m_dst = 0, m_cnt = 0, m_idx = 0;
  bit m_busy = 0, m_done = 0, m_run = 0, m_auto = 0, m_rv = 0;
  logic [31:0] m_rdata = '0;

  function automatic logic [31:0] model_read(int a);
    if (a == 'h000) return {m_busy, m_auto, 30'b0};
    if (a == 'h004) return 32'(m_src);
    if (a == 'h008) return 32'(m_dst);
    if (a == 'h00C) return 32'(m_cnt);
    if (a == 'h010) return {31'b0, m_done};
    if (a >= 'h090 && a <= 'h09C && a % 4 == 0) return m_ptr[(a - 'h090) / 4];
    if (a >= 'h400 && a <= 'h7FC && a % 4 == 0) return m_store[(a - 'h400) / 4];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_idx = 0;
      m_busy = 0; m_done = 0; m_run = 0; m_auto = 0; m_rv = 0;
      for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    end else begin
      bit pb, go;
      int a;
      pb = m_busy;
      a = int'(addr);
      m_rv = req && !we;
      if (m_rv) m_rdata = model_read(a);
      go = ((req && we && a == 0 && wdata[31]) || (pwr && m_auto)) && !pb;
      if (pb) begin
        m_idx++;
        if (m_idx == m_cnt) begin m_busy = 0; m_done = 1; m_run = 1; end
      end else if (go) begin
        if (m_cnt == 0) begin m_done = 1; m_run = 1; end
        else begin m_busy = 1; m_idx = 0; m_done = 0; m_run = 0; end
      end
      if (req && we) begin
        if (a == 'h000) m_auto = wdata[30];
        if (a == 'h004 && !pb) m_src = int'(wdata[7:0]);
        if (a == 'h008 && !pb) m_dst = int'(wdata[15:0]);
        if (a == 'h00C && !pb) m_cnt = int'(wdata[9:0]);
        if (a >= 'h090 && a <= 'h09C && a % 4 == 0) m_ptr[(a - 'h090) / 4] = wdata;
        if (a >= 'h400 && a <= 'h7FC && a % 4 == 0) m_store[(a - 'h400) / 4] = wdata;
      end
    end
  end

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      if (imem_we) n_writes++;
      chk(imem_we == m_busy, "R3 strobe", 32'(imem_we), 32'(m_busy));
      chk(run == m_run, "R6 run", 32'(run), 32'(m_run));
      if (m_busy) begin
        chk(imem_addr == 16'(m_dst + m_idx), "R3 addr", 32'(imem_addr), 32'(16'(m_dst + m_idx)));
        chk(imem_wdata == m_store[(m_src + m_idx) % 256], "R3/R4 data",
            imem_wdata, m_store[(m_src + m_idx) % 256]);
      end
      if (m_rv) chk(rdata == m_rdata, "R13 rdata", rdata, m_rdata);
    end
  end

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 12'(a); wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = 12'(a);
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr = 1;
    @(negedge clk); pwr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    chk(run == 0, "R1 run in reset", 32'(run), 0);
    chk(imem_we == 0, "R1 we in reset", 32'(imem_we), 0);
    rst_ni = 1;
    bus_rd('h000, d); chk(d == 0, "R1 ctrl", d, 0);
    bus_rd('h010, d); chk(d == 0, "R1 status", d, 0);
    bus_rd('h200, d); chk(d == 0, "R13 unmapped", d, 0);

    // R7: zero-count start
    n_writes = 0;
    bus_wr('h000, 32'h8000_0000);
    chk(run == 1, "R7 run", 32'(run), 1);
    bus_rd('h010, d); chk(d == 1, "R7 status", d, 1);
    bus_rd('h000, d); chk(d[31] == 0, "R7 go bit", d, 0);
    chk(n_writes == 0, "R7 no writes", n_writes, 0);

    // R11: fill and read back store
    for (int i = 0; i < 256; i++) bus_wr('h400 + 4 * i, 32'hC0DE_0000 + 32'(i * 7));
    bus_rd('h400 + 4 * 37, d); chk(d == 32'hC0DE_0000 + 37 * 7, "R11 readback", d, 32'hC0DE_0000 + 37 * 7);
    bus_rd('h7FC, d); chk(d == 32'hC0DE_0000 + 255 * 7, "R11 last word", d, 32'hC0DE_0000 + 255 * 7);

    // R2/R3/R5/R6: host copy
    bus_wr('h004, 2); bus_wr('h008, 'h100); bus_wr('h00C, 5);
    n_writes = 0;
    bus_wr('h000, 32'h8000_0000);
    chk(run == 0, "R6 run low", 32'(run), 0);
    bus_rd('h000, d); chk(d[31] == 1, "R2 go while busy", d, 32'h8000_0000);
    bus_rd('h010, d); chk(d == 0, "R5 status cleared", d, 0);
    idle(8);
    bus_rd('h000, d); chk(d[31] == 0, "R2 go cleared", d, 0);
    bus_rd('h010, d); chk(d == 1, "R5 status set", d, 1);
    chk(n_writes == 5, "R3 word count", n_writes, 5);

    // R10: parameter writes during copy
    bus_wr('h004, 0); bus_wr('h008, 'h200); bus_wr('h00C, 8);
    n_writes = 0;
    bus_wr('h000, 32'h8000_0000);
    bus_wr('h00C, 1); bus_wr('h004, 9);
    idle(10);
    chk(n_writes == 8, "R10 copy length kept", n_writes, 8);
    bus_rd('h00C, d); chk(d == 8, "R10 count kept", d, 8);
    bus_rd('h004, d); chk(d == 0, "R10 source kept", d, 0);

    // R4: wrap
    bus_wr('h004, 254); bus_wr('h008, 'h10); bus_wr('h00C, 4);
    n_writes = 0;
    bus_wr('h000, 32'h8000_0000);
    idle(6);
    chk(n_writes == 4, "R4 wrap count", n_writes, 4);

    // R9: power-up with enable clear
    n_writes = 0;
    pulse_pwr(); idle(4);
    chk(n_writes == 0, "R9 pwr ignored", n_writes, 0);

    // R8: auto reload, second pulse during copy ignored (R9)
    bus_wr('h004, 20); bus_wr('h008, 'h300); bus_wr('h00C, 6);
    bus_wr('h000, 32'h4000_0000);
    bus_rd('h000, d); chk(d == 32'h4000_0000, "R8 enable readback", d, 32'h4000_0000);
    n_writes = 0;
    pulse_pwr();
    chk(run == 0, "R8 run low", 32'(run), 0);
    pulse_pwr(); idle(10);
    chk(n_writes == 6, "R8/R9 auto copy length", n_writes, 6);
    chk(run == 1, "R8 run released", 32'(run), 1);

    // R11 persistence, R12 pointers
    bus_rd('h400 + 4 * 21, d); chk(d == 32'hC0DE_0000 + 21 * 7, "R11 kept", d, 32'hC0DE_0000 + 21 * 7);
    bus_wr('h090, 32'h1234_5678); bus_wr('h094, 32'h8000_0123);
    bus_wr('h098, 32'hDEAD_BEEF); bus_wr('h09C, 32'h0000_00FF);
    bus_rd('h094, d); chk(d == 32'h8000_0123, "R12 load flag", d, 32'h8000_0123);
    bus_rd('h090, d); chk(d == 32'h1234_5678, "R12 ptr0", d, 32'h1234_5678);
    bus_rd('h09C, d); chk(d == 32'h0000_00FF, "R12 ptr3", d, 32'h0000_00FF);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule